// File: doc/BRIEF.md
# Synchronous Serial Port Register File

This block is the software-facing half of a synchronous serial port. It sits on a simple 32-bit word-addressed register bus and holds everything a driver touches: two eight-entry circular queues (outbound and inbound), a frame-size and clock-prescale configuration, a control word, a status word, a four-source interrupt unit with raw, masked and write-one-to-clear views, and a read-only identification area near the top of a 4 KB window. It drives one level-sensitive interrupt line.

The shifting of bits onto the wire is done by a separate transfer engine. This block gives that engine the head of the outbound queue and a pop strobe, a push port into the inbound queue, the frame-width mask and the control bits. It also takes a busy level and two event pulses from the engine: receive overrun and receive timeout. Bus reads are registered, so read data appears one cycle after the read strobe. A read of the data word removes the oldest inbound entry on that same edge.

Top module: `ssp_regfile`

## Requirements
- R1: After a synchronous active-low reset, the status word (offset 0x0C) reads 0x03, the raw interrupt word (0x18) reads 0x08, the masked word (0x1C) reads 0x00 and `irq` is low.
- R2: Status bits: bit0 outbound queue empty, bit1 outbound queue not full, bit2 inbound queue not empty, bit3 inbound queue full, bit4 follows `eng_busy`.
- R3: A write to the data word (0x08) appends the value ANDed with the frame mask to the outbound queue. The frame mask has bits 0..n set, where n is bits 3:0 of the frame word (0x00). The write is dropped when the outbound queue already holds 8 entries.
- R4: A read of the data word returns the oldest inbound entry and removes it. Entries come out in arrival order. When the inbound queue is empty the read returns 0 and changes nothing.
- R5: Raw bit2 (receive level) is 1 while the inbound queue holds 4 or more entries. Raw bit3 (transmit level) is 1 while the outbound queue holds 4 or fewer. Neither bit is stored.
- R6: Raw bit0 (overrun) and raw bit1 (timeout) are set by `eng_ovr_evt` and `eng_tmo_evt` and stay set. They are cleared only by writing 1 to bit0 or bit1 of the clear word (0x20). Writing bits 2 and 3 of the clear word has no effect. If an event and a clear arrive in the same cycle, the event wins.
- R7: The masked word reads as raw AND mask (mask word 0x14, 4 bits). `irq` is high exactly when that value is nonzero.
- R8: Word reads at 0xFE0, 0xFE4, ..., 0xFFC return 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R9: Read-back widths: the frame word keeps 16 bits, the control word (0x04) keeps 4 bits and the prescale word (0x10) keeps 8 bits. The DMA control word (0x24), the clear word and unmapped offsets read as 0, and writes to the DMA control word are ignored.
- R10: `eng_rx_push` stores `eng_rx_data` ANDed with the frame mask, and is dropped when the inbound queue is full. `eng_tx_pop` is ignored when the outbound queue is empty. `eng_tx_valid` and `eng_rx_ready` report not-empty and not-full.
- R11: The control word drives `ctl_loopback` (bit0), `ctl_enable` (bit1), `ctl_slave` (bit2) and `ctl_out_dis` (bit3). `frame_mask` presents the current frame mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt |
| eng_tx_valid | output | 1 | Outbound queue not empty |
| eng_tx_data | output | 16 | Head of the outbound queue |
| eng_tx_pop | input | 1 | Engine removes the outbound head |
| eng_rx_ready | output | 1 | Inbound queue not full |
| eng_rx_push | input | 1 | Engine stores a received frame |
| eng_rx_data | input | 16 | Received frame |
| eng_busy | input | 1 | Engine is shifting a frame |
| eng_ovr_evt | input | 1 | Receive overrun pulse |
| eng_tmo_evt | input | 1 | Receive timeout pulse |
| frame_mask | output | 16 | Frame-width mask |
| ctl_loopback | output | 1 | Control bit0 |
| ctl_enable | output | 1 | Control bit1 |
| ctl_slave | output | 1 | Control bit2 |
| ctl_out_dis | output | 1 | Control bit3 |

## Verification
The hardest states to reach are the two full queues with a ninth entry offered. These are the only places where the drop rules and the queue-full status bits can be seen together with the threshold interrupt bits moving between 3, 4 and 8 entries. The stimulus fills the outbound queue from the bus without popping it, then pushes nine frames into the inbound queue from the engine side without draining it. After that it empties both queues one entry at a time, comparing each entry against a queue of expected values, so that a dropped ninth entry would show up as an extra or out-of-order item. The sticky overrun and timeout bits are driven by single-cycle event pulses and cleared with mixed clear patterns.

// File: rtl/ssp_regs_pkg.sv
// Package: shared offsets, interrupt bit positions and identification bytes
// for the serial port register file. Assumes a 12-bit byte address.
package ssp_regs_pkg;

    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;
    localparam int CR0_W  = 16;
    localparam int CR1_W  = 4;
    localparam int PRE_W  = 8;
    localparam int IRQ_N  = 4;

    // Word offsets (byte address bits 11:2)
    localparam logic [ADDR_W-3:0] W_FRAME = 10'h000;
    localparam logic [ADDR_W-3:0] W_CTRL  = 10'h001;
    localparam logic [ADDR_W-3:0] W_DATA  = 10'h002;
    localparam logic [ADDR_W-3:0] W_STAT  = 10'h003;
    localparam logic [ADDR_W-3:0] W_PRE   = 10'h004;
    localparam logic [ADDR_W-3:0] W_MASK  = 10'h005;
    localparam logic [ADDR_W-3:0] W_RAW   = 10'h006;
    localparam logic [ADDR_W-3:0] W_MIS   = 10'h007;
    localparam logic [ADDR_W-3:0] W_CLR   = 10'h008;
    localparam logic [ADDR_W-3:0] W_DMA   = 10'h009;

    // Interrupt source positions
    localparam int IRQ_OVR = 0;
    localparam int IRQ_TMO = 1;
    localparam int IRQ_RXL = 2;
    localparam int IRQ_TXL = 3;

    // Identification byte for word index 0..7 of the top area
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h22;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
// Module: circular queue with occupancy count. Push when full and pop when
// empty are ignored; both may occur in one cycle. Head is combinational.
module ssp_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        nxt = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ssp_irq.sv
// Module: interrupt sources. Overrun and timeout are sticky, set by engine
// pulses and cleared by write-one-to-clear (set wins). Receive and transmit
// level bits follow the queue occupancy against half-depth thresholds.
module ssp_irq
    import ssp_regs_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             ovr_evt,
    input  logic             tmo_evt,
    input  logic             clr_we,
    input  logic [1:0]       clr_bits,
    input  logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] raw,
    output logic             irq
);
    logic ovr_q, tmo_q;

    // Sticky event bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            if (ovr_evt)                  ovr_q <= 1'b1;
            else if (clr_we && clr_bits[0]) ovr_q <= 1'b0;
            if (tmo_evt)                  tmo_q <= 1'b1;
            else if (clr_we && clr_bits[1]) tmo_q <= 1'b0;
        end
    end

    // Raw vector assembly and masked line
    always_comb begin
        raw          = '0;
        raw[IRQ_OVR] = ovr_q;
        raw[IRQ_TMO] = tmo_q;
        raw[IRQ_RXL] = (rx_count >= CNT_W'(HALF));
        raw[IRQ_TXL] = (tx_count <= CNT_W'(HALF));
        irq          = |(raw & mask);
    end
endmodule

// File: rtl/ssp_regfile.sv
// Module: register file of a synchronous serial port. Word-addressed bus with
// registered read data; a data-word read pops the inbound queue on the
// strobe edge. Assumes bus_sel is a single-cycle strobe per access.
module ssp_regfile
    import ssp_regs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    output logic              eng_rx_ready,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    input  logic              eng_ovr_evt,
    input  logic              eng_tmo_evt,
    output logic [DATA_W-1:0] frame_mask,
    output logic              ctl_loopback,
    output logic              ctl_enable,
    output logic              ctl_slave,
    output logic              ctl_out_dis
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CR0_W-1:0]  frame_q;
    logic [CR1_W-1:0]  ctrl_q;
    logic [PRE_W-1:0]  pre_q;
    logic [IRQ_N-1:0]  mask_q;
    logic [ADDR_W-3:0] widx;
    logic              wr_en, rd_en, id_hit;
    logic              tx_push, rx_pop;
    logic [DATA_W-1:0] tx_head, rx_head, tx_din, rx_din;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [IRQ_N-1:0]  raw;
    logic [31:0]       rd_next;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign wr_en  = bus_sel && bus_wr;
    assign rd_en  = bus_sel && !bus_wr;
    assign id_hit = (bus_addr[ADDR_W-1:5] == '1);

    // Frame-width mask: bits 0..n set, n from the frame word
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            frame_mask[i] = (i <= int'(frame_q[3:0]));
    end

    assign tx_push = wr_en && (widx == W_DATA);
    assign rx_pop  = rd_en && (widx == W_DATA);
    assign tx_din  = bus_wdata[DATA_W-1:0] & frame_mask;
    assign rx_din  = eng_rx_data & frame_mask;

    ssp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_din),
        .pop(eng_tx_pop), .head(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(eng_rx_push), .din(rx_din),
        .pop(rx_pop), .head(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    ssp_irq #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .ovr_evt(eng_ovr_evt), .tmo_evt(eng_tmo_evt),
        .clr_we(wr_en && (widx == W_CLR)), .clr_bits(bus_wdata[1:0]),
        .mask(mask_q), .raw(raw), .irq(irq)
    );

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            ctrl_q  <= '0;
            pre_q   <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (widx)
                W_FRAME: frame_q <= bus_wdata[CR0_W-1:0];
                W_CTRL:  ctrl_q  <= bus_wdata[CR1_W-1:0];
                W_PRE:   pre_q   <= bus_wdata[PRE_W-1:0];
                W_MASK:  mask_q  <= bus_wdata[IRQ_N-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        rd_next = '0;
        if (id_hit) begin
            rd_next[7:0] = id_byte(bus_addr[4:2]);
        end else begin
            case (widx)
                W_FRAME: rd_next[CR0_W-1:0] = frame_q;
                W_CTRL:  rd_next[CR1_W-1:0] = ctrl_q;
                W_DATA:  rd_next[DATA_W-1:0] = rx_empty ? '0 : rx_head;
                W_STAT:  rd_next[4:0] = {eng_busy, rx_full, !rx_empty,
                                         !tx_full, tx_empty};
                W_PRE:   rd_next[PRE_W-1:0] = pre_q;
                W_MASK:  rd_next[IRQ_N-1:0] = mask_q;
                W_RAW:   rd_next[IRQ_N-1:0] = raw;
                W_MIS:   rd_next[IRQ_N-1:0] = raw & mask_q;
                default: rd_next = '0;
            endcase
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_en)  bus_rdata <= rd_next;
    end

    assign eng_tx_valid = !tx_empty;
    assign eng_tx_data  = tx_head;
    assign eng_rx_ready = !rx_full;
    assign ctl_loopback = ctrl_q[0];
    assign ctl_enable   = ctrl_q[1];
    assign ctl_slave    = ctrl_q[2];
    assign ctl_out_dis  = ctrl_q[3];
endmodule

// File: rtl/ssp_regfile_chk.sv
// Checker: temporal properties of the register file, bound to every
// ssp_regfile instance. Observes ports and internal queue/interrupt state.
module ssp_regfile_chk #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             eng_tx_pop,
    input logic             eng_rx_push,
    input logic             eng_ovr_evt,
    input logic             eng_tmo_evt,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic [3:0]       raw,
    input logic [3:0]       mask_q
);
    logic is_data, is_clr, is_mis;
    assign is_data = (bus_addr[11:2] == 10'h002);
    assign is_clr  = (bus_addr[11:2] == 10'h008);
    assign is_mis  = (bus_addr[11:2] == 10'h007);

    // R1: reset leaves only the transmit level source raised
    p_reset_raw_r1: assert property (@(posedge clk)
        !rst_n |=> (raw == 4'b1000));

    // R3: a data write into a full outbound queue is dropped
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && is_data && tx_count == CNT_W'(DEPTH) && !eng_tx_pop)
        |=> (tx_count == CNT_W'(DEPTH)));

    // R4: reading an empty inbound queue yields zero and keeps it empty
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && is_data && rx_count == '0 && !eng_rx_push)
        |=> (bus_rdata == 32'd0 && rx_count == '0));

    // R5: occupancy never exceeds the depth
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    // R6: overrun clears after a clear write with bit0 and no new event
    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && is_clr && bus_wdata[0] && !eng_ovr_evt)
        |=> !raw[0]);

    // R6: timeout stays set unless cleared with bit1
    p_tmo_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[1] && !(bus_sel && bus_wr && is_clr && bus_wdata[1]))
        |=> raw[1]);

    // R7: masked read returns raw AND mask of the strobe cycle
    p_mis_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && is_mis)
        |=> (bus_rdata[3:0] == $past(raw & mask_q)));
endmodule

bind ssp_regfile ssp_regfile_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
    .eng_ovr_evt(eng_ovr_evt), .eng_tmo_evt(eng_tmo_evt),
    .tx_count(tx_count), .rx_count(rx_count), .raw(raw), .mask_q(mask_q)
);

// File: tb/ssp_regfile_tb.sv
// Bench: scoreboard for bus reads (driver queues expectations, monitor
// compares registered read data) plus direct checks of engine-side outputs.
module ssp_regfile_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq, eng_tx_valid, eng_rx_ready;
    logic [DW-1:0] eng_tx_data, frame_mask;
    logic          eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          eng_busy = 1'b0, eng_ovr_evt = 1'b0, eng_tmo_evt = 1'b0;
    logic          ctl_loopback, ctl_enable, ctl_slave, ctl_out_dis;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    ssp_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_ready(eng_rx_ready),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_busy(eng_busy), .eng_ovr_evt(eng_ovr_evt),
        .eng_tmo_evt(eng_tmo_evt), .frame_mask(frame_mask),
        .ctl_loopback(ctl_loopback), .ctl_enable(ctl_enable),
        .ctl_slave(ctl_slave), .ctl_out_dis(ctl_out_dis)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic eng_pop(input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        chk({31'd0, eng_tx_valid}, 32'd1, tag);
        chk({16'd0, eng_tx_data}, {16'd0, exp}, tag);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [DW-1:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    // Monitor: compare registered read data one cycle after each read strobe
    always begin
        @(posedge clk);
        if (bus_sel && !bus_wr) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard empty actual=0x%0h expected=none", bus_rdata);
            end else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk({31'd0, irq}, 32'd0, "R1 irq");
        bus_read(12'h00C, 32'h03, "R1 status");
        bus_read(12'h018, 32'h08, "R1 raw");
        bus_read(12'h01C, 32'h00, "R1 masked");

        // R11/R3: frame mask from frame word
        bus_write(12'h000, 32'h000F);
        @(negedge clk);
        chk({16'd0, frame_mask}, 32'hFFFF, "R11 mask n=15");
        bus_write(12'h000, 32'h0003);
        bus_write(12'h008, 32'h00AB);
        eng_pop(16'h000B, "R3 width 4");

        bus_write(12'h000, 32'hABC7);
        bus_read(12'h000, 32'hABC7, "R9 frame 16 bits");
        @(negedge clk);
        chk({16'd0, frame_mask}, 32'h00FF, "R11 mask n=7");

        // R3/R2/R5: fill outbound queue, offer a ninth
        bus_write(12'h008, 32'h01A5);
        for (int i = 1; i < 8; i++) bus_write(12'h008, 32'h100 + i * 3);
        bus_read(12'h00C, 32'h00, "R2 tx full status");
        bus_read(12'h018, 32'h00, "R5 tx level off at 8");
        bus_write(12'h008, 32'h0077);
        eng_pop(16'h00A5, "R3 order");
        for (int i = 1; i < 8; i++) eng_pop(16'(i * 3), "R3 order");
        @(negedge clk);
        chk({31'd0, eng_tx_valid}, 32'd0, "R3 ninth dropped");
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
        bus_read(12'h00C, 32'h03, "R10 pop on empty ignored");

        // R10/R5/R2: inbound queue
        for (int i = 0; i < 3; i++) eng_push(16'h3C0 + 16'(i));
        bus_read(12'h018, 32'h08, "R5 rx level off at 3");
        eng_push(16'h3C3);
        bus_read(12'h018, 32'h0C, "R5 rx level on at 4");
        for (int i = 4; i < 8; i++) eng_push(16'h3C0 + 16'(i));
        @(negedge clk);
        chk({31'd0, eng_rx_ready}, 32'd0, "R10 rx ready low");
        bus_read(12'h00C, 32'h0F, "R2 rx full status");
        eng_push(16'h3EE);
        for (int i = 0; i < 8; i++) bus_read(12'h008, 32'hC0 + i, "R4 R10 rx order");
        bus_read(12'h008, 32'h00, "R4 empty read zero");
        bus_read(12'h00C, 32'h03, "R4 empty unchanged");

        // R2: busy bit
        eng_busy = 1'b1;
        bus_read(12'h00C, 32'h13, "R2 busy");
        eng_busy = 1'b0;

        // R6/R7: sticky sources and clearing
        @(negedge clk); eng_ovr_evt = 1'b1;
        @(negedge clk); eng_ovr_evt = 1'b0;
        bus_read(12'h018, 32'h09, "R6 overrun set");
        bus_write(12'h014, 32'h1);
        @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R7 irq overrun");
        bus_read(12'h01C, 32'h01, "R7 masked");
        bus_write(12'h020, 32'hC);
        bus_read(12'h018, 32'h09, "R6 bits 2-3 no clear");
        bus_write(12'h020, 32'h1);
        bus_read(12'h018, 32'h08, "R6 overrun cleared");
        @(negedge clk);
        chk({31'd0, irq}, 32'd0, "R7 irq low");
        @(negedge clk); eng_tmo_evt = 1'b1;
        @(negedge clk); eng_tmo_evt = 1'b0;
        bus_read(12'h018, 32'h0A, "R6 timeout set");
        bus_write(12'h020, 32'h2);
        bus_read(12'h018, 32'h08, "R6 timeout cleared");
        bus_write(12'h014, 32'h8);
        @(negedge clk);
        chk({31'd0, irq}, 32'd1, "R7 irq tx level");
        bus_read(12'h01C, 32'h08, "R7 masked tx");

        // R8: identification bytes
        bus_read(12'hFE0, 32'h22, "R8 id0");
        bus_read(12'hFE4, 32'h10, "R8 id1");
        bus_read(12'hFE8, 32'h04, "R8 id2");
        bus_read(12'hFEC, 32'h00, "R8 id3");
        bus_read(12'hFF0, 32'h0D, "R8 id4");
        bus_read(12'hFF4, 32'hF0, "R8 id5");
        bus_read(12'hFF8, 32'h05, "R8 id6");
        bus_read(12'hFFC, 32'hB1, "R8 id7");

        // R9/R11: widths, dead words, control outputs
        bus_write(12'h010, 32'h1FF);
        bus_read(12'h010, 32'hFF, "R9 prescale 8 bits");
        bus_write(12'h004, 32'hFF);
        bus_read(12'h004, 32'h0F, "R9 control 4 bits");
        @(negedge clk);
        chk({28'd0, ctl_out_dis, ctl_slave, ctl_enable, ctl_loopback}, 32'hF, "R11 ctl all");
        bus_write(12'h004, 32'h2);
        @(negedge clk);
        chk({28'd0, ctl_out_dis, ctl_slave, ctl_enable, ctl_loopback}, 32'h2, "R11 ctl enable");
        bus_write(12'h024, 32'hFFFF);
        bus_read(12'h024, 32'h0, "R9 dma zero");
        bus_read(12'h020, 32'h0, "R9 clear word zero");
        bus_read(12'h040, 32'h0, "R9 unmapped zero");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule